// File: doc/BRIEF.md
# DRAM Page-Mode Burst Sequencer

This block turns a stream of host beats into page-mode strobe sequences for a bank of multiplexed-address DRAM chips that share row and column address lines. The first beat of a burst opens the page: its row goes onto the address lines and RAS falls once. Each later beat that targets the same row uses the open page. The column is placed on the address lines, and the one CAS line picked by the beat's chip index is pulsed. Because each chip has its own CAS line, one open row reaches 128 columns in every chip, so the page spans the whole bank and not a single device.

Each beat carries a row, a column, a chip index, a read/write flag, write data and a burst-continue flag, all under a valid/ready handshake. Writes use early-write timing. WE falls and write data is driven one cycle before CAS falls, so the data outputs of the chips stay released. The chip data output is not latched, so a read is captured in the last cycle that CAS is low. It is then returned on a one-cycle pulse. The page is released when the host ends the burst, when the next beat names another row, or when another beat would push the RAS-low time past its configured limit. All strobe phase lengths are clock-count parameters.

Top module: `dram_page_burst`

## Requirements
- R1: RAS falls once per page, with the beat's row on `mem_addr` in the first RAS-low cycle. Later beats with the same row and the continue flag set reuse the page without RAS rising. CAS is never low while RAS is high.
- R2: For every beat, `mem_addr` holds the column in the cycle that CAS falls, and CAS stays low for exactly T_CAS cycles.
- R3: Each beat drives exactly one line low: `mem_cas_n[i]`, where i is the beat's chip index. The other lines stay high.
- R4: Between two beats in the same page, the CAS lines stay high for at least T_CP cycles.
- R5: On a read beat, WE stays high and the address holds steady while CAS is low. `mem_dout` is sampled in the last CAS-low cycle and returned on `rd_data` with a one-cycle `rd_valid` pulse. Reads come back in beat order.
- R6: On a write beat, WE is low in the cycle before CAS falls and stays low while CAS is low. `mem_din` carries the beat's data, which is stored at the addressed chip, row and column. A write beat never produces `rd_valid`.
- R7: A beat with `beat_last` = 1 closes the page once its CAS precharge ends. RAS then stays high for at least T_RP cycles before it falls again.
- R8: No RAS-low run exceeds RAS_MAX_CYC cycles. If a further beat would exceed the limit, the page is closed and the beat runs on a newly opened page. An idle open page is closed before the limit is reached.
- R9: A beat whose row differs from the open row is not accepted on that page. The page is closed and reopened with the new row.
- R10: While reset is asserted, RAS, every CAS line and WE are high, and `rd_valid` and `beat_ready` are low. After release, `beat_ready` is high in the idle state.
- R11: While a page is open, the last beat had the continue flag set and no beat is offered, RAS stays low (subject to R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| beat_valid | input | 1 | Host offers a beat |
| beat_ready | output | 1 | Beat is taken at this clock edge |
| beat_row | input | ROW_W | Row address of the beat |
| beat_col | input | COL_W | Column address of the beat |
| beat_chip | input | CHIP_W | Chip index selecting one CAS line |
| beat_write | input | 1 | 1 = write beat, 0 = read beat |
| beat_wdata | input | DATA_W | Write data |
| beat_last | input | 1 | 1 = close the page after this beat |
| rd_valid | output | 1 | One-cycle pulse: read data available |
| rd_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | NUM_CHIPS | One column strobe per chip, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_din | output | DATA_W | Data to the chips |
| mem_dout | input | DATA_W | Unlatched data from the chips |

## Verification
With a one-cycle CAS precharge, the first precharge cycle after a read does two jobs. The `rd_valid` pulse for that read appears, and the sequencer decides whether to take the next beat, close the page on the RAS-time limit, or close it on a row miss. A long back-to-back read stream over every column of every chip forces this cycle many times, and some instances land on the limit-forced close. The bench compares every returned word, in order, against a shadow memory filled by the earlier writes. It also compares the number of RAS falls with the count derived from the beat length and the RAS-time limit.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;

  // sequencer phases
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,  // page closed, waiting for a beat
    ST_ROW    = 4'd1,  // row on the address lines, RAS still high
    ST_RCD    = 4'd2,  // RAS low, row-to-column delay
    ST_COL    = 4'd3,  // column on the address lines, WE set up
    ST_STROBE = 4'd4,  // CAS low
    ST_CPRE   = 4'd5,  // CAS precharge, decision on its last cycle
    ST_HOLD   = 4'd6,  // page open, waiting for the next beat
    ST_RPRE   = 4'd7   // RAS precharge
  } dps_state_e;

  function automatic logic ras_is_low(input dps_state_e s);
    return (s == ST_RCD) || (s == ST_COL) || (s == ST_STROBE) ||
           (s == ST_CPRE) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/dps_phase_timer.sv
`timescale 1ns/1ps
module dps_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dps_ras_window.sv
`timescale 1ns/1ps
module dps_ras_window #(
  parameter int RAS_MAX_CYC = 64,
  parameter int BEAT_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic room
);

  localparam int CNT_W = $clog2(RAS_MAX_CYC + 2) + 1;
  localparam int LIMIT = RAS_MAX_CYC - BEAT_CYC - 1;
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] SAT_V   = {CNT_W{1'b1}};

  // index of the current RAS-low cycle (0 in the first one)
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_d;

  always_comb begin
    if (!ras_low)           run_d = '0;
    else if (run_q != SAT_V) run_d = run_q + 1'b1;
    else                    run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // a beat taken now ends its precharge at index run_q + BEAT_CYC;
  // closing right after keeps the run at run_q + BEAT_CYC + 1 cycles
  assign room = (run_q <= LIMIT_V);

endmodule

// File: rtl/dps_cas_decode.sv
`timescale 1ns/1ps
module dps_cas_decode #(
  parameter int NUM_CHIPS = 4,
  parameter int CHIP_W    = 2
) (
  input  logic              strobe,
  input  logic [CHIP_W-1:0] chip,
  output logic [NUM_CHIPS-1:0] cas_n
);

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_line
    assign cas_n[g] = !(strobe && (chip == CHIP_W'(g)));
  end

endmodule

// File: rtl/dram_page_burst.sv
`timescale 1ns/1ps
module dram_page_burst
  import dps_pkg::*;
#(
  parameter int NUM_CHIPS   = 4,
  parameter int ROW_W       = 7,
  parameter int COL_W       = 7,
  parameter int DATA_W      = 8,
  parameter int T_RCD       = 2,
  parameter int T_CAS       = 2,
  parameter int T_CP        = 1,
  parameter int T_RP        = 2,
  parameter int RAS_MAX_CYC = 64,
  localparam int CHIP_W     = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
  localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat_valid,
  output logic                 beat_ready,
  input  logic [ROW_W-1:0]     beat_row,
  input  logic [COL_W-1:0]     beat_col,
  input  logic [CHIP_W-1:0]    beat_chip,
  input  logic                 beat_write,
  input  logic [DATA_W-1:0]    beat_wdata,
  input  logic                 beat_last,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_ras_n,
  output logic [NUM_CHIPS-1:0] mem_cas_n,
  output logic                 mem_we_n,
  output logic [DATA_W-1:0]    mem_din,
  input  logic [DATA_W-1:0]    mem_dout
);

  localparam int BEAT_CYC = 1 + T_CAS + T_CP;
  localparam int T_MAX_A  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_MAX_B  = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int T_MAX    = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int TMR_W    = $clog2(T_MAX + 1);
  localparam logic [TMR_W-1:0] LD_RCD = TMR_W'(T_RCD - 1);
  localparam logic [TMR_W-1:0] LD_CAS = TMR_W'(T_CAS - 1);
  localparam logic [TMR_W-1:0] LD_CP  = TMR_W'(T_CP - 1);
  localparam logic [TMR_W-1:0] LD_RP  = TMR_W'(T_RP - 1);

  // ---------------- reset release synchronizer ----------------
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  // ---------------- state and beat registers ----------------
  dps_state_e          state_q, state_d;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q;
  logic [CHIP_W-1:0]   chip_q;
  logic                wr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                last_q;
  logic [DATA_W-1:0]   rd_data_q;
  logic                rd_valid_q;

  logic                tmr_load;
  logic [TMR_W-1:0]    tmr_val;
  logic                tmr_zero;
  logic                room;
  logic                row_hit;
  logic                chain_ok;
  logic                take_beat;
  logic                cap_rd;
  logic                ras_low_now;

  assign ras_low_now = ras_is_low(state_q);
  assign row_hit     = (beat_row == row_q);
  assign chain_ok    = row_hit && room;

  // ---------------- submodules ----------------
  dps_phase_timer #(
    .CNT_W   (TMR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_zero)
  );

  dps_ras_window #(
    .RAS_MAX_CYC(RAS_MAX_CYC),
    .BEAT_CYC   (BEAT_CYC)
  ) u_window (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ras_low(ras_low_now),
    .room   (room)
  );

  dps_cas_decode #(
    .NUM_CHIPS(NUM_CHIPS),
    .CHIP_W   (CHIP_W)
  ) u_cas (
    .strobe(state_q == ST_STROBE),
    .chip  (chip_q),
    .cas_n (mem_cas_n)
  );

  // ---------------- handshake ----------------
  always_comb begin
    beat_ready = 1'b0;
    if (rst_core_n) begin
      case (state_q)
        ST_IDLE: beat_ready = 1'b1;
        ST_CPRE: beat_ready = tmr_zero && !last_q && chain_ok;
        ST_HOLD: beat_ready = chain_ok;
        default: beat_ready = 1'b0;
      endcase
    end
  end

  assign take_beat = beat_valid && beat_ready;

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_rd   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take_beat) state_d = ST_ROW;
      end
      ST_ROW: begin
        state_d  = ST_RCD;
        tmr_load = 1'b1;
        tmr_val  = LD_RCD;
      end
      ST_RCD: begin
        if (tmr_zero) state_d = ST_COL;
      end
      ST_COL: begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = LD_CAS;
      end
      ST_STROBE: begin
        if (tmr_zero) begin
          cap_rd   = !wr_q;
          state_d  = ST_CPRE;
          tmr_load = 1'b1;
          tmr_val  = LD_CP;
        end
      end
      ST_CPRE: begin
        if (tmr_zero) begin
          if (take_beat) begin
            state_d = ST_COL;
          end else if (last_q || beat_valid || !room) begin
            state_d  = ST_RPRE;
            tmr_load = 1'b1;
            tmr_val  = LD_RP;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (take_beat) begin
          state_d = ST_COL;
        end else if (beat_valid || !room) begin
          state_d  = ST_RPRE;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
        end
      end
      ST_RPRE: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      row_q   <= '0;
      col_q   <= '0;
      chip_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      last_q  <= 1'b0;
    end else if (take_beat) begin
      row_q   <= beat_row;
      col_q   <= beat_col;
      chip_q  <= beat_chip;
      wr_q    <= beat_write;
      wdata_q <= beat_wdata;
      last_q  <= beat_last;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rd_data_q <= '0;
    else if (cap_rd) rd_data_q <= mem_dout;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rd_valid_q <= 1'b0;
    else             rd_valid_q <= cap_rd;
  end

  // ---------------- memory-side outputs ----------------
  always_comb begin
    if ((state_q == ST_ROW) || (state_q == ST_RCD)) mem_addr = ADDR_W'(row_q);
    else                                            mem_addr = ADDR_W'(col_q);
  end

  assign mem_ras_n = !ras_low_now;
  assign mem_we_n  = !(wr_q && ((state_q == ST_COL) || (state_q == ST_STROBE)));
  assign mem_din   = wdata_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;

endmodule

// File: rtl/dps_burst_checker.sv
`timescale 1ns/1ps
module dps_burst_checker #(
  parameter int NUM_CHIPS   = 4,
  parameter int ADDR_W      = 7,
  parameter int T_CAS       = 2,
  parameter int T_CP        = 1,
  parameter int RAS_MAX_CYC = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mem_ras_n,
  input logic [NUM_CHIPS-1:0] mem_cas_n,
  input logic                 mem_we_n,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic                 rd_valid
);

  logic        cas_any;
  logic [31:0] ras_run_q;   // index of current RAS-low cycle
  logic [31:0] cas_low_q;   // consecutive CAS-low cycles so far
  logic [31:0] cas_gap_q;   // consecutive CAS-high cycles so far
  logic        seen_q;      // a CAS pulse already happened in this page

  assign cas_any = |(~mem_cas_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_run_q <= '0;
      cas_low_q <= '0;
      cas_gap_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      ras_run_q <= mem_ras_n ? 32'd0 : ras_run_q + 32'd1;
      cas_low_q <= cas_any ? cas_low_q + 32'd1 : 32'd0;
      cas_gap_q <= cas_any ? 32'd0 : cas_gap_q + 32'd1;
      if (mem_ras_n)    seen_q <= 1'b0;
      else if (cas_any) seen_q <= 1'b1;
    end
  end

  assert_cas_inside_ras_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cas_any |-> !mem_ras_n);

  assert_cas_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_any && $past(cas_any)) |-> (cas_low_q == 32'(T_CAS)));

  assert_cas_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cas_n));

  assert_cas_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_any) && seen_q) |-> (cas_gap_q >= 32'(T_CP)));

  assert_strobe_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_any && $past(cas_any)) |-> ($stable(mem_we_n) && $stable(mem_addr)));

  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_early_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_any) && !mem_we_n) |-> $past(!mem_we_n));

  assert_ras_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ras_n |-> (ras_run_q < 32'(RAS_MAX_CYC)));

endmodule

bind dram_page_burst dps_burst_checker #(
  .NUM_CHIPS  (NUM_CHIPS),
  .ADDR_W     (ADDR_W),
  .T_CAS      (T_CAS),
  .T_CP       (T_CP),
  .RAS_MAX_CYC(RAS_MAX_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n),
  .mem_we_n (mem_we_n),
  .mem_addr (mem_addr),
  .rd_valid (rd_valid)
);

// File: tb/dram_page_burst_tb_top.sv
`timescale 1ns/1ps
module dram_page_burst_tb_top;

  localparam int NUM_CHIPS   = 4;
  localparam int ROW_W       = 7;
  localparam int COL_W       = 7;
  localparam int DATA_W      = 8;
  localparam int T_RCD       = 2;
  localparam int T_CAS       = 2;
  localparam int T_CP        = 1;
  localparam int T_RP        = 2;
  localparam int RAS_MAX_CYC = 64;
  localparam int CHIP_W      = 2;
  localparam int ADDR_W      = 7;
  localparam int BEAT_CYC    = 1 + T_CAS + T_CP;
  localparam int PER_PAGE    = 2 + (RAS_MAX_CYC - T_RCD - 2 * BEAT_CYC) / BEAT_CYC;
  localparam int COLS        = 1 << COL_W;

  logic                 clk;
  logic                 rst_n;
  logic                 beat_valid;
  logic                 beat_ready;
  logic [ROW_W-1:0]     beat_row;
  logic [COL_W-1:0]     beat_col;
  logic [CHIP_W-1:0]    beat_chip;
  logic                 beat_write;
  logic [DATA_W-1:0]    beat_wdata;
  logic                 beat_last;
  logic                 rd_valid;
  logic [DATA_W-1:0]    rd_data;
  logic [ADDR_W-1:0]    mem_addr;
  logic                 mem_ras_n;
  logic [NUM_CHIPS-1:0] mem_cas_n;
  logic                 mem_we_n;
  logic [DATA_W-1:0]    mem_din;
  logic [DATA_W-1:0]    mem_dout;

  dram_page_burst #(
    .NUM_CHIPS(NUM_CHIPS), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
    .RAS_MAX_CYC(RAS_MAX_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_row(beat_row), .beat_col(beat_col), .beat_chip(beat_chip),
    .beat_write(beat_write), .beat_wdata(beat_wdata), .beat_last(beat_last),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_din(mem_din), .mem_dout(mem_dout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // index into model / shadow: chip, low two row bits, column
  function automatic int idx(input int chip, input int row, input int col);
    return (chip * 4 + (row % 4)) * COLS + col;
  endfunction

  function automatic logic [DATA_W-1:0] pat(input int chip, input int row, input int col, input int salt);
    return DATA_W'((col * 3 + chip * 37 + row * 11 + salt * 29) ^ 8'h5A);
  endfunction

  // ---------------- DRAM model (sampled at negedge) ----------------
  logic [DATA_W-1:0] model_mem [NUM_CHIPS*4*COLS];
  logic [DATA_W-1:0] shadow    [NUM_CHIPS*4*COLS];
  int  mrow = 0;
  bit  p_ras_low = 0;
  bit  p_cas_any = 0;
  bit  p_we_n = 1;
  bit  seen_ras = 0;
  bit  cas_in_page = 0;
  int  ras_run = 0, ras_high = 0, cas_low_run = 0, cas_high_run = 0;
  int  ras_falls = 0;

  function automatic int cas_chip(input logic [NUM_CHIPS-1:0] cn);
    int r = 0;
    for (int i = 0; i < NUM_CHIPS; i++) if (!cn[i]) r = i;
    return r;
  endfunction

  always_comb begin
    if ((mem_cas_n != '1) && mem_we_n)
      mem_dout = model_mem[idx(cas_chip(mem_cas_n), mrow, int'(mem_addr))];
    else
      mem_dout = '0;
  end

  always @(negedge clk) begin
    bit ras_low;
    bit cas_any;
    ras_low = !mem_ras_n;
    cas_any = (mem_cas_n != '1);
    if (rst_n) begin
      if (ras_low && !p_ras_low) begin
        ras_falls++;
        if (seen_ras) chk(ras_high >= T_RP, "R7 RAS precharge cycles", ras_high, T_RP);
        seen_ras = 1;
        mrow = int'(mem_addr);
        ras_run = 1;
        cas_in_page = 0;
      end else if (ras_low) ras_run++;
      if (!ras_low && p_ras_low) begin
        chk(ras_run <= RAS_MAX_CYC, "R8 RAS low run", ras_run, RAS_MAX_CYC);
        ras_high = 1;
      end else if (!ras_low) ras_high++;

      if (cas_any && !p_cas_any) begin
        chk($countones(~mem_cas_n) == 1, "R3 single CAS line", $countones(~mem_cas_n), 1);
        chk(ras_low, "R1 CAS inside RAS", int'(ras_low), 1);
        if (cas_in_page) chk(cas_high_run >= T_CP, "R4 CAS precharge", cas_high_run, T_CP);
        if (!mem_we_n) begin
          chk(!p_we_n, "R6 WE low before CAS", int'(p_we_n), 0);
          model_mem[idx(cas_chip(mem_cas_n), mrow, int'(mem_addr))] = mem_din;
        end
        cas_in_page = 1;
        cas_low_run = 1;
      end else if (cas_any) begin
        cas_low_run++;
        chk(mem_we_n == p_we_n, "R5 WE steady during CAS", int'(mem_we_n), int'(p_we_n));
      end
      if (!cas_any && p_cas_any) begin
        chk(cas_low_run == T_CAS, "R2 CAS low width", cas_low_run, T_CAS);
        cas_high_run = 1;
      end else if (!cas_any) cas_high_run++;
    end
    p_ras_low = ras_low;
    p_cas_any = cas_any;
    p_we_n    = mem_we_n;
  end

  // ---------------- read return monitor ----------------
  logic [DATA_W-1:0] exp_q [1024];
  int wp = 0, rp = 0;

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (rp == wp) begin
        chk(1'b0, "R6 rd_valid without a read", 1, 0);
      end else begin
        chk(rd_data == exp_q[rp % 1024], "R5 read data", int'(rd_data), int'(exp_q[rp % 1024]));
        rp++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input int row, input int col, input int chip, input bit wr,
                      input bit last, input int salt);
    @(negedge clk);
    beat_valid = 1'b1;
    beat_row   = ROW_W'(row);
    beat_col   = COL_W'(col);
    beat_chip  = CHIP_W'(chip);
    beat_write = wr;
    beat_wdata = pat(chip, row, col, salt);
    beat_last  = last;
    #1;
    while (!beat_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    if (wr) shadow[idx(chip, row, col)] = pat(chip, row, col, salt);
    else begin
      exp_q[wp % 1024] = shadow[idx(chip, row, col)];
      wp++;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    beat_valid = 1'b0;
    #1;
    while (!(beat_ready && mem_ras_n)) begin
      @(negedge clk);
      #1;
    end
    repeat (3) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int f0;
    for (int i = 0; i < NUM_CHIPS * 4 * COLS; i++) begin
      model_mem[i] = '0;
      shadow[i]    = '0;
    end
    rst_n = 1'b0;
    beat_valid = 1'b0; beat_row = '0; beat_col = '0; beat_chip = '0;
    beat_write = 1'b0; beat_wdata = '0; beat_last = 1'b0;
    repeat (4) @(negedge clk);
    chk(mem_ras_n == 1'b1, "R10 RAS idle in reset", int'(mem_ras_n), 1);
    chk(mem_cas_n == '1, "R10 CAS idle in reset", int'(mem_cas_n), 15);
    chk(mem_we_n == 1'b1, "R10 WE idle in reset", int'(mem_we_n), 1);
    chk(rd_valid == 1'b0, "R10 rd_valid in reset", int'(rd_valid), 0);
    chk(beat_ready == 1'b0, "R10 ready in reset", int'(beat_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(beat_ready == 1'b1, "R10 ready after release", int'(beat_ready), 1);

    // R1: one page, four chips, writes then reads
    f0 = ras_falls;
    for (int c = 0; c < 4; c++) send(1, 10 + c, c, 1'b1, c == 3, 0);
    drain();
    chk(ras_falls - f0 == 1, "R1 single RAS fall for write burst", ras_falls - f0, 1);
    f0 = ras_falls;
    for (int c = 0; c < 4; c++) send(1, 10 + c, c, 1'b0, c == 3, 0);
    drain();
    chk(ras_falls - f0 == 1, "R1 single RAS fall for read burst", ras_falls - f0, 1);

    // R9: row changes inside a stream
    f0 = ras_falls;
    send(1, 20, 0, 1'b1, 1'b0, 1);
    send(2, 20, 1, 1'b1, 1'b0, 1);
    send(2, 21, 1, 1'b0, 1'b0, 1);
    send(1, 20, 0, 1'b0, 1'b1, 1);
    drain();
    chk(ras_falls - f0 == 3, "R9 reopen on row change", ras_falls - f0, 3);

    // R11: open page held while host pauses
    f0 = ras_falls;
    send(3, 5, 2, 1'b1, 1'b0, 2);
    @(negedge clk); beat_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(mem_ras_n == 1'b0, "R11 page held open", int'(mem_ras_n), 0);
    send(3, 6, 2, 1'b0, 1'b1, 2);
    drain();
    chk(ras_falls - f0 == 1, "R11 paused burst keeps one page", ras_falls - f0, 1);

    // R8: idle open page closes before the limit
    f0 = ras_falls;
    send(3, 7, 3, 1'b1, 1'b0, 3);
    @(negedge clk); beat_valid = 1'b0;
    repeat (RAS_MAX_CYC + 20) @(negedge clk);
    chk(mem_ras_n == 1'b1, "R8 idle page closed", int'(mem_ras_n), 1);
    chk(ras_falls - f0 == 1, "R8 idle page single fall", ras_falls - f0, 1);
    drain();

    // R8 sweep: every chip and column of row 0, written then read back
    f0 = ras_falls;
    for (int c = 0; c < NUM_CHIPS; c++)
      for (int k = 0; k < COLS; k++)
        send(0, k, c, 1'b1, (c == NUM_CHIPS - 1) && (k == COLS - 1), 4);
    drain();
    chk(ras_falls - f0 == (NUM_CHIPS * COLS + PER_PAGE - 1) / PER_PAGE,
        "R8 pages for write sweep", ras_falls - f0, (NUM_CHIPS * COLS + PER_PAGE - 1) / PER_PAGE);
    f0 = ras_falls;
    for (int c = 0; c < NUM_CHIPS; c++)
      for (int k = 0; k < COLS; k++)
        send(0, k, c, 1'b0, (c == NUM_CHIPS - 1) && (k == COLS - 1), 4);
    drain();
    chk(ras_falls - f0 == (NUM_CHIPS * COLS + PER_PAGE - 1) / PER_PAGE,
        "R8 pages for read sweep", ras_falls - f0, (NUM_CHIPS * COLS + PER_PAGE - 1) / PER_PAGE);

    // R5/R6: write then read of the same column inside one page stream
    for (int k = 0; k < 64; k++) begin
      send(2, k, k % NUM_CHIPS, 1'b1, 1'b0, 5 + k);
      send(2, k, k % NUM_CHIPS, 1'b0, k == 63, 5 + k);
    end
    drain();

    // R6: model contents agree with every write the bench issued
    for (int i = 0; i < NUM_CHIPS * 4 * COLS; i++)
      if (model_mem[i] != shadow[i])
        chk(1'b0, "R6 stored write data", int'(model_mem[i]), int'(shadow[i]));
    chk(1'b1, "R6 stored write data scan", 1, 1);
    chk(rp == wp, "R5 all reads returned", rp, wp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule